// File: doc/BRIEF.md
# Bridge Short Fault Latch

This block turns the results of drain-source voltage comparators on a three-phase MOSFET bridge into one short-circuit fault flag and one output-disable signal. Each phase has a high-side and a low-side FET. For each FET the block receives a comparator bit that reports an excessive drain-source voltage, and the gate-on command for that FET. The block evaluates a comparator bit only while that FET's gate command is active. It also waits out a programmable blanking interval after each turn-on, so that switching transients are not reported as faults.

An excess on a high-side FET means a phase is shorted to ground. An excess on a low-side FET means a phase is shorted to supply. An excess on both FETs of one phase means a shorted winding. All three cases drive the same active-low fault flag.

A stop-on-fault strap selects between two ways of handling a short:
- With the strap low, the flag follows detection and the outputs are never disabled.
- With the strap high, the first detection latches. It disables all bridge outputs and holds the flag low until one of three events: the next commutation pulse, the reset going low, or the coast input going low.

Top module: `bridge_short_latch`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, faultN is 1 and outDisable is 0. Driving rstN low clears a latched fault asynchronously.
- R2: A set vdsHi[p] bit (high-side excess, short to ground) on a FET that is past blanking drives faultN to 0 at the next rising clock edge.
- R3: A set vdsLo[p] bit (low-side excess, short to supply) on a FET that is past blanking drives faultN to 0 at the next rising clock edge.
- R4: When both vdsHi[p] and vdsLo[p] of one phase p are set and both FETs are past blanking (shorted winding), faultN is 0 at the next edge.
- R5: Blanking. Let D be the value of deadTime. A comparator bit is ignored during the first D clock cycles in which its gate bit is 1, and is evaluated from cycle D+1 on. With D = 0 it is evaluated from the first cycle. Blanking restarts each time the gate bit goes from 0 to 1.
- R6: A comparator bit whose gate bit (gateHi[p] or gateLo[p]) is 0 has no effect on faultN or outDisable.
- R7: With stopOnFault = 0, outDisable stays 0. faultN is the inverse of the detection one cycle earlier, so it returns to 1 one edge after the excess ends.
- R8: With stopOnFault = 1, a detection drives outDisable to 1 and faultN to 0 at the next edge. Both hold after the excess ends, until the fault latch is cleared.
- R9: A cycle with commPulse = 1 clears the fault latch, so outDisable is 0 after that edge. A clear has priority over a detection in the same cycle.
- R10: While coastN is 0, the fault latch is cleared and comparators are not evaluated: outDisable is 0 and faultN is 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; clears the fault latch |
| coastN | input | 1 | Active-low coast; clears the latch and suppresses evaluation |
| commPulse | input | 1 | One-cycle commutation event; clears the latch |
| stopOnFault | input | 1 | 1: latch a short and disable the outputs; 0: flag only |
| deadTime | input | DT_W | Blanking length in clock cycles; 0 means no blanking |
| gateHi | input | PHASES | High-side gate-on command, bit p is phase p |
| gateLo | input | PHASES | Low-side gate-on command, bit p is phase p |
| vdsHi | input | PHASES | High-side drain-source excess comparator, bit p is phase p |
| vdsLo | input | PHASES | Low-side drain-source excess comparator, bit p is phase p |
| faultN | output | 1 | Active-low short fault flag |
| outDisable | output | 1 | 1 disables all bridge outputs (latched short) |

## Verification
The assertions assume the following about the inputs:
- deadTime is held steady while any gate is on.
- commPulse and coastN are synchronous to clk.
- The comparator bits are already clean logic levels.

Under these assumptions, detection can be predicted from a count of consecutive gate-on cycles for each FET. The stimulus changes deadTime only while all gates are off and drives every input at the falling edge. Comparator excesses are removed before a commutation pulse whenever the test expects the latch to stay clear after the pulse.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  typedef struct packed {
    logic sampleEn;
    logic latchSet;
    logic latchClr;
  } bsfStrobes_t;
endpackage

// File: rtl/bsf_blanker.sv
module bsf_blanker #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DT_W-1:0] deadTime,
  input  logic            gate,
  input  logic            cmp,
  output logic            hit
);
  logic            gatePrev;
  logic [DT_W-1:0] blankCnt;
  logic            gateRise;
  logic            sampleOk;

  assign gateRise = gate && !gatePrev;
  // On the turn-on cycle only a zero interval allows sampling.
  assign sampleOk = gateRise ? (deadTime == '0) : (blankCnt == '0);
  assign hit      = gate && sampleOk && cmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      blankCnt <= '0;
    end else begin
      gatePrev <= gate;
      if (!gate)
        blankCnt <= '0;
      else if (gateRise)
        blankCnt <= (deadTime == '0) ? '0 : deadTime - 1'b1;
      else if (blankCnt != '0)
        blankCnt <= blankCnt - 1'b1;
    end
  end
endmodule

// File: rtl/bsf_datapath.sv
module bsf_datapath
  import bsf_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int DT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DT_W-1:0]   deadTime,
  input  logic [PHASES-1:0] gateHi,
  input  logic [PHASES-1:0] gateLo,
  input  logic [PHASES-1:0] vdsHi,
  input  logic [PHASES-1:0] vdsLo,
  input  bsfStrobes_t       strobes,
  output logic              detect,
  output logic              faultN,
  output logic              outDisable
);
  localparam int FETS = 2 * PHASES;

  logic [FETS-1:0]   gateAll;
  logic [FETS-1:0]   vdsAll;
  logic [FETS-1:0]   hitAll;
  logic [PHASES-1:0] hiHit;
  logic [PHASES-1:0] loHit;
  logic              gndShort;
  logic              supShort;
  logic              windShort;
  logic              flagReg;
  logic              latchReg;

  assign gateAll = {gateLo, gateHi};
  assign vdsAll  = {vdsLo, vdsHi};

  for (genvar f = 0; f < FETS; f++) begin : g_fet
    bsf_blanker #(.DT_W(DT_W)) u_blank (
      .clk      (clk),
      .rstN     (rstN),
      .deadTime (deadTime),
      .gate     (gateAll[f]),
      .cmp      (vdsAll[f]),
      .hit      (hitAll[f])
    );
  end

  assign hiHit     = hitAll[PHASES-1:0];
  assign loHit     = hitAll[FETS-1:PHASES];
  assign gndShort  = |hiHit;
  assign supShort  = |loHit;
  assign windShort = |(hiHit & loHit);
  assign detect    = strobes.sampleEn && (gndShort || supShort || windShort);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg  <= 1'b0;
      latchReg <= 1'b0;
    end else begin
      flagReg <= detect;
      if (strobes.latchClr)
        latchReg <= 1'b0;
      else if (strobes.latchSet)
        latchReg <= 1'b1;
    end
  end

  assign faultN     = !(flagReg || latchReg);
  assign outDisable = latchReg;
endmodule

// File: rtl/bsf_control.sv
module bsf_control
  import bsf_pkg::*;
(
  input  logic        coastN,
  input  logic        commPulse,
  input  logic        stopOnFault,
  input  logic        detect,
  output bsfStrobes_t strobes
);
  always_comb begin
    strobes.sampleEn = coastN;
    strobes.latchClr = commPulse || !coastN;
    strobes.latchSet = stopOnFault && detect && !strobes.latchClr;
  end
endmodule

// File: rtl/bridge_short_latch.sv
module bridge_short_latch
  import bsf_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int DT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coastN,
  input  logic              commPulse,
  input  logic              stopOnFault,
  input  logic [DT_W-1:0]   deadTime,
  input  logic [PHASES-1:0] gateHi,
  input  logic [PHASES-1:0] gateLo,
  input  logic [PHASES-1:0] vdsHi,
  input  logic [PHASES-1:0] vdsLo,
  output logic              faultN,
  output logic              outDisable
);
  bsfStrobes_t strobes;
  logic        detect;

  bsf_control u_ctl (
    .coastN      (coastN),
    .commPulse   (commPulse),
    .stopOnFault (stopOnFault),
    .detect      (detect),
    .strobes     (strobes)
  );

  bsf_datapath #(.PHASES(PHASES), .DT_W(DT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .deadTime   (deadTime),
    .gateHi     (gateHi),
    .gateLo     (gateLo),
    .vdsHi      (vdsHi),
    .vdsLo      (vdsLo),
    .strobes    (strobes),
    .detect     (detect),
    .faultN     (faultN),
    .outDisable (outDisable)
  );
endmodule

// File: rtl/bridge_short_latch_chk.sv
module bridge_short_latch_chk #(
  parameter int PHASES = 3,
  parameter int DT_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              coastN,
  input logic              commPulse,
  input logic              stopOnFault,
  input logic [DT_W-1:0]   deadTime,
  input logic [PHASES-1:0] gateHi,
  input logic [PHASES-1:0] gateLo,
  input logic [PHASES-1:0] vdsHi,
  input logic [PHASES-1:0] vdsLo,
  input logic              detect,
  input logic              faultN,
  input logic              outDisable
);
  localparam int FETS = 2 * PHASES;
  localparam int CW   = DT_W + 1;

  logic [FETS-1:0] gAll;
  logic [FETS-1:0] cAll;
  logic [CW-1:0]   onCnt [FETS];
  logic [FETS-1:0] okAll;
  logic            permitted;

  assign gAll = {gateLo, gateHi};
  assign cAll = {vdsLo, vdsHi};

  // Count earlier consecutive gate-on cycles per FET, saturating.
  for (genvar f = 0; f < FETS; f++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        onCnt[f] <= '0;
      else if (!gAll[f])
        onCnt[f] <= '0;
      else if (onCnt[f] != {CW{1'b1}})
        onCnt[f] <= onCnt[f] + 1'b1;
    end
    assign okAll[f] = gAll[f] && cAll[f] && (onCnt[f] >= {1'b0, deadTime});
  end
  assign permitted = coastN && (|okAll);

  assert_blank_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    detect |-> permitted);
  assert_gate_off_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi == '0 && gateLo == '0 && !outDisable) |=> faultN);
  assert_no_disable_flag_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stopOnFault && !outDisable) |=> !outDisable);
  assert_disable_means_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> !faultN);
  assert_disable_needs_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outDisable) |-> $past(stopOnFault));
  assert_comm_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    commPulse |=> !outDisable);
  assert_coast_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    !coastN |=> (!outDisable && faultN));
endmodule

bind bridge_short_latch bridge_short_latch_chk #(.PHASES(PHASES), .DT_W(DT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .coastN      (coastN),
  .commPulse   (commPulse),
  .stopOnFault (stopOnFault),
  .deadTime    (deadTime),
  .gateHi      (gateHi),
  .gateLo      (gateLo),
  .vdsHi       (vdsHi),
  .vdsLo       (vdsLo),
  .detect      (detect),
  .faultN      (faultN),
  .outDisable  (outDisable)
);

// File: tb/bridge_short_latch_bench.sv
module bridge_short_latch_bench;
  localparam int PHASES = 3;
  localparam int DT_W   = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              coastN;
  logic              commPulse;
  logic              stopOnFault;
  logic [DT_W-1:0]   deadTime;
  logic [PHASES-1:0] gateHi;
  logic [PHASES-1:0] gateLo;
  logic [PHASES-1:0] vdsHi;
  logic [PHASES-1:0] vdsLo;
  logic              faultN;
  logic              outDisable;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bridge_short_latch #(.PHASES(PHASES), .DT_W(DT_W)) u_bridge_short_latch (
    .clk(clk), .rstN(rstN), .coastN(coastN), .commPulse(commPulse),
    .stopOnFault(stopOnFault), .deadTime(deadTime), .gateHi(gateHi),
    .gateLo(gateLo), .vdsHi(vdsHi), .vdsLo(vdsLo),
    .faultN(faultN), .outDisable(outDisable)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle();
    gateHi = '0; gateLo = '0; vdsHi = '0; vdsLo = '0;
    commPulse = 1'b0; coastN = 1'b1;
  endtask

  task automatic t_reset_R1();
    rstN = 1'b0; idle(); stopOnFault = 1'b0; deadTime = 8'd0;
    step(2);
    chk(faultN, 1'b1, "R1 faultN in reset");
    chk(outDisable, 1'b0, "R1 outDisable in reset");
    rstN = 1'b1;
    step(1);
    chk(faultN, 1'b1, "R1 faultN after reset");
  endtask

  task automatic t_high_side_blank_R2();
    idle(); stopOnFault = 1'b0; deadTime = 8'd4;
    step(1);
    gateHi = 3'b001; vdsHi = 3'b001;
    step(4);
    chk(faultN, 1'b1, "R5 blanked during 4 cycles");
    step(1);
    chk(faultN, 1'b0, "R2 high-side short flagged");
    chk(outDisable, 1'b0, "R7 no disable with stop off");
    vdsHi = '0;
    step(1);
    chk(faultN, 1'b1, "R7 flag releases");
    idle(); step(1);
  endtask

  task automatic t_low_side_R3();
    idle(); stopOnFault = 1'b0; deadTime = 8'd2;
    step(1);
    gateLo = 3'b100; vdsLo = 3'b100;
    step(2);
    chk(faultN, 1'b1, "R5 low-side blanked");
    step(1);
    chk(faultN, 1'b0, "R3 low-side short flagged");
    idle(); step(2);
    chk(faultN, 1'b1, "R3 flag cleared after removal");
  endtask

  task automatic t_winding_R4();
    idle(); stopOnFault = 1'b0; deadTime = 8'd0;
    step(1);
    gateHi = 3'b010; gateLo = 3'b010; vdsHi = 3'b010; vdsLo = 3'b010;
    step(1);
    chk(faultN, 1'b0, "R4 winding short, no blanking");
    idle(); step(2);
  endtask

  task automatic t_gate_off_R6();
    idle(); stopOnFault = 1'b1; deadTime = 8'd0;
    step(1);
    gateHi = 3'b001; vdsHi = 3'b110; vdsLo = 3'b111;
    step(3);
    chk(faultN, 1'b1, "R6 comparators of off FETs ignored");
    chk(outDisable, 1'b0, "R6 no disable from off FETs");
    idle(); step(1);
  endtask

  task automatic t_restart_R5();
    idle(); stopOnFault = 1'b0; deadTime = 8'd3;
    step(1);
    gateHi = 3'b100;
    step(2);
    gateHi = 3'b000;
    step(1);
    gateHi = 3'b100; vdsHi = 3'b100;
    step(3);
    chk(faultN, 1'b1, "R5 blanking restarted on re-turn-on");
    step(1);
    chk(faultN, 1'b0, "R5 evaluated after restart interval");
    idle(); step(2);
  endtask

  task automatic t_latch_comm_R8();
    idle(); stopOnFault = 1'b1; deadTime = 8'd1;
    step(1);
    gateLo = 3'b001; vdsLo = 3'b001;
    step(1);
    chk(outDisable, 1'b0, "R5 blanked first cycle");
    step(1);
    chk(outDisable, 1'b1, "R8 latched disable");
    chk(faultN, 1'b0, "R8 flag with latch");
    vdsLo = '0;
    step(3);
    chk(outDisable, 1'b1, "R8 latch holds");
    commPulse = 1'b1;
    step(1);
    commPulse = 1'b0;
    chk(outDisable, 1'b0, "R9 commutation clears");
    chk(faultN, 1'b1, "R9 flag released");
    idle(); step(1);
  endtask

  task automatic t_comm_priority_R9();
    idle(); stopOnFault = 1'b1; deadTime = 8'd0;
    step(1);
    gateHi = 3'b010; vdsHi = 3'b010; commPulse = 1'b1;
    step(1);
    commPulse = 1'b0;
    chk(outDisable, 1'b0, "R9 clear wins over set");
    step(1);
    chk(outDisable, 1'b1, "R8 sets once clear ends");
    idle(); commPulse = 1'b1; step(1); commPulse = 1'b0; step(1);
  endtask

  task automatic t_coast_R10();
    idle(); stopOnFault = 1'b1; deadTime = 8'd0;
    step(1);
    gateHi = 3'b001; vdsHi = 3'b001;
    step(1);
    chk(outDisable, 1'b1, "R8 latched before coast");
    coastN = 1'b0;
    step(1);
    chk(outDisable, 1'b0, "R10 coast clears latch");
    chk(faultN, 1'b1, "R10 coast suppresses evaluation");
    idle(); step(1);
  endtask

  task automatic t_reset_clears_R1();
    idle(); stopOnFault = 1'b1; deadTime = 8'd0;
    step(1);
    gateLo = 3'b010; vdsLo = 3'b010;
    step(1);
    vdsLo = '0;
    step(1);
    chk(outDisable, 1'b1, "R8 latched before reset");
    rstN = 1'b0;
    #1;
    chk(outDisable, 1'b0, "R1 reset clears latch");
    step(1);
    rstN = 1'b1; idle(); step(1);
  endtask

  initial begin
    fork
      begin
        t_reset_R1();
        t_high_side_blank_R2();
        t_low_side_R3();
        t_winding_R4();
        t_gate_off_R6();
        t_restart_R5();
        t_latch_comm_R8();
        t_comm_priority_R9();
        t_coast_R10();
        t_reset_clears_R1();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule